// File: doc/BRIEF.md
# Secure Doorbell Mailbox Register Unit

This block is a small register file that lets an application processor and a system control processor ring each other's doorbells. Two secure channels carry notifications, one in each direction. Each channel exposes three words on a simple 32-bit register bus: a status word, a write-one-to-set word and a write-one-to-clear word. Every bus request carries a security attribute.

A sender raises a slot by writing a one to that slot's bit in the set word. The receiver sees a level interrupt and reads the status word. It acknowledges by writing the same bit to the clear word. Bits 30 to 0 are usable slots. Bit 31 of each status word is a sticky flag that hardware raises when a non-secure master touches that channel's registers. Such an access otherwise changes nothing and reads back zero.

The bus accepts one request per cycle when `bus_valid` is high. Read data is returned with `rsp_valid` in the following cycle.

Top module: `doorbell_mbox`

## Requirements
- R1: Channel 0 (controller to processor) occupies offsets 0x200 (status), 0x208 (set) and 0x210 (clear). Channel 1 (processor to controller) occupies 0x300 (status), 0x308 (set) and 0x310 (clear). A read returns its data with `rsp_valid` high in the cycle after the request.
- R2: A secure write to a set offset ORs bits 30..0 of the written word into that channel's status. Zero bits leave their status bits unchanged.
- R3: A secure write to a clear offset clears every status bit whose written bit is one. Zero bits leave their status bits unchanged.
- R4: A one written to bit 31 of a set offset never sets status bit 31.
- R5: A non-secure access, read or write, to any of a channel's three offsets sets bit 31 of that channel's status. It changes no other state, and a read returns zero.
- R6: Status bit 31 is cleared only by a secure write with bit 31 set to that channel's clear offset. Clearing slots 30..0 leaves it set.
- R7: `irq_to_host` is high exactly when any of bits 30..0 of channel 0's status is set. `irq_to_ctrl` does the same for channel 1. Bit 31 alone raises neither.
- R8: Reads of set and clear offsets return zero.
- R9: Accesses to unmapped offsets read zero and change no status.
- R10: After reset both status words are zero and both interrupts are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Request present this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_secure | input | 1 | 1 = secure master |
| bus_addr | input | 12 | Byte offset |
| bus_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid (one cycle after a read request) |
| rsp_rdata | output | 32 | Read data |
| irq_to_host | output | 1 | Level interrupt from channel 0 |
| irq_to_ctrl | output | 1 | Level interrupt from channel 1 |

## Verification
A request sampled at clock edge t updates status at that same edge. The interrupt outputs therefore follow within edge t. Read data and `rsp_valid` appear after edge t and hold for one cycle. The bench drives every request on a falling edge and queues the expected read word. The monitor then compares it on the falling edge after the sampling edge. Interrupt levels are compared against the bench's own status model on that same falling edge, so each result is checked half a cycle after it becomes due.

// File: rtl/db_pkg.sv
// Shared types for the doorbell mailbox.
// Assumes word-aligned offsets; only the low 12 address bits are decoded.
package db_pkg;
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_STAT = 2'd1,
        SEL_SET  = 2'd2,
        SEL_CLR  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic     hit;
        logic     ch;
        reg_sel_e sel;
    } dec_t;
endpackage

// File: rtl/db_decode.sv
// Address decoder: maps a byte offset onto (channel, register kind).
// Assumes channels are laid out at BASE0 + i*CH_STRIDE with three words
// at +0 (status), +SET_OFS (set) and +CLR_OFS (clear).
module db_decode
    import db_pkg::*;
#(
    parameter int AW        = 12,
    parameter int NCH       = 2,
    parameter int BASE0     = 'h200,
    parameter int CH_STRIDE = 'h100,
    parameter int SET_OFS   = 'h8,
    parameter int CLR_OFS   = 'h10
) (
    input  logic [AW-1:0] addr,
    output dec_t          dec
);
    logic [NCH-1:0] hit_stat, hit_set, hit_clr;

    // Per-channel comparators, one set for each channel.
    for (genvar i = 0; i < NCH; i++) begin : g_cmp
        localparam logic [AW-1:0] BASE = AW'(BASE0 + i * CH_STRIDE);
        assign hit_stat[i] = (addr == BASE);
        assign hit_set[i]  = (addr == BASE + AW'(SET_OFS));
        assign hit_clr[i]  = (addr == BASE + AW'(CLR_OFS));
    end

    // Fold comparator hits into one decode record.
    always_comb begin
        dec = '{hit: 1'b0, ch: 1'b0, sel: SEL_NONE};
        for (int i = 0; i < NCH; i++) begin
            if (hit_stat[i] | hit_set[i] | hit_clr[i]) begin
                dec.hit = 1'b1;
                dec.ch  = 1'(i);
                dec.sel = hit_stat[i] ? SEL_STAT : (hit_set[i] ? SEL_SET : SEL_CLR);
            end
        end
    end
endmodule

// File: rtl/db_channel.sv
// One doorbell channel: status word with set/clear strobes and a sticky
// violation flag in the top bit. Clear takes priority over set.
// Assumes strobes are already qualified by the security check.
module db_channel #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_we,
    input  logic          clr_we,
    input  logic          viol,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] stat,
    output logic          irq
);
    localparam logic [DW-1:0] SLOT_MASK = {1'b0, {(DW-1){1'b1}}};

    logic [DW-1:0] stat_nxt;

    // Next status: OR in set bits (slots only), then apply clear, then flag.
    always_comb begin
        stat_nxt = stat | (set_we ? (wdata & SLOT_MASK) : '0);
        stat_nxt = stat_nxt & ~(clr_we ? wdata : '0);
        if (viol) stat_nxt[DW-1] = 1'b1;
    end

    // Status register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) stat <= '0;
        else        stat <= stat_nxt;
    end

    assign irq = |(stat & SLOT_MASK);
endmodule

// File: rtl/doorbell_mbox.sv
// Top of the secure doorbell mailbox. Decodes bus requests, enforces the
// secure-only rule, updates the channel status words and returns read data
// one cycle after a read request.
// Assumes at most one request per cycle on the register bus.
module doorbell_mbox
    import db_pkg::*;
#(
    parameter int AW  = 12,
    parameter int DW  = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_valid,
    input  logic          bus_write,
    input  logic          bus_secure,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    output logic          irq_to_host,
    output logic          irq_to_ctrl
);
    localparam int NCH = 2;

    dec_t          dec;
    logic          acc_ok, acc_bad;
    logic [DW-1:0] chan_stat [NCH];
    logic [NCH-1:0] chan_irq;

    db_decode #(.AW(AW), .NCH(NCH)) u_dec (
        .addr (bus_addr),
        .dec  (dec)
    );

    assign acc_ok  = bus_valid &  bus_secure & dec.hit;
    assign acc_bad = bus_valid & ~bus_secure & dec.hit;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic sel_me;
        assign sel_me = (dec.ch == 1'(i));
        db_channel #(.DW(DW)) u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_we (acc_ok & bus_write & sel_me & (dec.sel == SEL_SET)),
            .clr_we (acc_ok & bus_write & sel_me & (dec.sel == SEL_CLR)),
            .viol   (acc_bad & sel_me),
            .wdata  (bus_wdata),
            .stat   (chan_stat[i]),
            .irq    (chan_irq[i])
        );
    end

    assign irq_to_host = chan_irq[0];
    assign irq_to_ctrl = chan_irq[1];

    // Read response register: status only for secure status reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= bus_valid & ~bus_write;
            rsp_rdata <= (acc_ok & ~bus_write & (dec.sel == SEL_STAT))
                         ? chan_stat[dec.ch] : '0;
        end
    end
endmodule

// File: rtl/db_mbox_checker.sv
// Temporal checks on the doorbell mailbox, bound to the top module.
module db_mbox_checker #(
    parameter int AW = 12,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_valid,
    input logic          bus_write,
    input logic          bus_secure,
    input logic [AW-1:0] bus_addr,
    input logic [DW-1:0] bus_wdata,
    input logic          rsp_valid,
    input logic [DW-1:0] rsp_rdata,
    input logic          irq_to_host,
    input logic          irq_to_ctrl,
    input logic [DW-1:0] stat0,
    input logic [DW-1:0] stat1
);
    // R7/R2: channel 1 interrupt rises only after a secure write to its set word
    a_r7_irq_ctrl_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_to_ctrl) |-> $past(bus_valid && bus_write && bus_secure && bus_addr == AW'('h308)));

    // R3: channel 1 interrupt falls only after a secure write to its clear word
    a_r3_irq_ctrl_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_to_ctrl) |-> $past(bus_valid && bus_write && bus_secure && bus_addr == AW'('h310)));

    // R4/R5: the flag bit rises only after a non-secure request
    a_r4_flag_from_ns_only: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(stat0[DW-1]) || $rose(stat1[DW-1])) |-> $past(bus_valid && !bus_secure));

    // R5: a non-secure read returns zero
    a_r5_ns_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(!bus_secure)) |-> (rsp_rdata == '0));

    // R5: a non-secure request leaves all slot bits unchanged
    a_r5_ns_slots_kept: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_valid && !bus_secure) |->
            (stat0[DW-2:0] == $past(stat0[DW-2:0]) && stat1[DW-2:0] == $past(stat1[DW-2:0])));

    // R6: the flag bit falls only after a secure clear write with its bit set
    a_r6_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(stat0[DW-1]) || $fell(stat1[DW-1])) |->
            $past(bus_valid && bus_write && bus_secure && bus_wdata[DW-1]));

    // R1: read response appears only one cycle after a read request
    a_r1_rsp_timing: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(bus_valid && !bus_write));
endmodule

bind doorbell_mbox db_mbox_checker #(.AW(AW), .DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_valid   (bus_valid),
    .bus_write   (bus_write),
    .bus_secure  (bus_secure),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .rsp_valid   (rsp_valid),
    .rsp_rdata   (rsp_rdata),
    .irq_to_host (irq_to_host),
    .irq_to_ctrl (irq_to_ctrl),
    .stat0       (chan_stat[0]),
    .stat1       (chan_stat[1])
);

// File: tb/tb_doorbell_mbox.sv
`timescale 1ns/1ps
module tb_doorbell_mbox;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_write = 1'b0, bus_secure = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        irq_to_host, irq_to_ctrl;

    int checks = 0;
    int errors = 0;
    logic [31:0] m [2];
    logic [31:0] exp_q [$];
    string       tag_q [$];
    bit          done = 0;

    always #2.5 clk = ~clk;

    doorbell_mbox dut (.*);

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Driver: one request, model update, expected read pushed to scoreboard.
    task automatic access(bit wr, bit sec, logic [11:0] a, logic [31:0] d, string req);
        bit hit;
        bit ch;
        logic [31:0] exp;
        hit = (a == 12'h200 || a == 12'h208 || a == 12'h210 ||
               a == 12'h300 || a == 12'h308 || a == 12'h310);
        ch  = a[8];
        exp = (hit && sec && a[4:0] == 5'h0) ? m[ch] : 32'h0;
        @(negedge clk);
        bus_valid = 1; bus_write = wr; bus_secure = sec; bus_addr = a; bus_wdata = d;
        if (!wr) begin exp_q.push_back(exp); tag_q.push_back(req); end
        if (hit && !sec) m[ch][31] = 1'b1;
        else if (hit && wr && a[4:0] == 5'h08) m[ch] = m[ch] | (d & 32'h7fff_ffff);
        else if (hit && wr && a[4:0] == 5'h10) m[ch] = m[ch] & ~d;
        @(negedge clk);
        bus_valid = 0;
        check("R7 irq_to_host", 32'(irq_to_host), 32'(|m[0][30:0]));
        check("R7 irq_to_ctrl", 32'(irq_to_ctrl), 32'(|m[1][30:0]));
    endtask

    // Monitor: pops expected read words as responses appear.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) check("R1 unexpected rsp", 32'h1, 32'h0);
            else check(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
        end
    end

    task automatic read_all(string req);
        access(0, 1, 12'h200, 0, req); access(0, 1, 12'h300, 0, req);
    endtask

    initial begin
        m[0] = 0; m[1] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R10 reset state
        check("R10 irq_to_host", 32'(irq_to_host), 0);
        check("R10 irq_to_ctrl", 32'(irq_to_ctrl), 0);
        read_all("R10 reset status");
        // R2 set on channel 1
        access(1, 1, 12'h308, 32'h0000_0005, "R2");
        access(0, 1, 12'h300, 0, "R2 R1 status after set");
        // R4 bit 31 of set ignored
        access(1, 1, 12'h308, 32'h8000_0010, "R4");
        access(0, 1, 12'h300, 0, "R4 status without flag");
        // R8 set/clear read zero
        access(0, 1, 12'h308, 0, "R8 set reads zero");
        access(0, 1, 12'h310, 0, "R8 clear reads zero");
        access(0, 1, 12'h208, 0, "R8 set reads zero ch0");
        // R3 partial clear
        access(1, 1, 12'h310, 32'h0000_0004, "R3");
        access(0, 1, 12'h300, 0, "R3 status after clear");
        // R5 non-secure write to channel 0 set
        access(1, 0, 12'h208, 32'h0000_000f, "R5");
        access(0, 1, 12'h200, 0, "R5 flag only on ch0");
        // R5 non-secure read returns zero and flags channel 1
        access(0, 0, 12'h300, 0, "R5 ns read zero");
        access(0, 1, 12'h300, 0, "R5 flag on ch1");
        // R6 slot clear leaves flag
        access(1, 1, 12'h310, 32'h7fff_ffff, "R6");
        access(0, 1, 12'h300, 0, "R6 flag kept");
        access(1, 1, 12'h310, 32'h8000_0000, "R6 flag clear");
        access(0, 1, 12'h300, 0, "R6 flag cleared");
        // R9 unmapped offsets
        access(1, 1, 12'h204, 32'hffff_ffff, "R9");
        access(1, 1, 12'h408, 32'hffff_ffff, "R9");
        access(0, 1, 12'h30c, 0, "R9 unmapped read zero");
        read_all("R9 status unchanged");
        // R2/R7 top slot boundary on channel 0
        access(1, 1, 12'h208, 32'h4000_0000, "R2 slot 30");
        access(0, 1, 12'h200, 0, "R2 slot 30 status");
        access(1, 1, 12'h210, 32'hffff_ffff, "R3 clear all");
        read_all("R3 all clear");
        repeat (3) @(negedge clk);
        check("R1 queue drained", 32'(exp_q.size()), 0);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                check("watchdog", 32'h1, 32'h0);
            end
        join_any
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule